// File: doc/BRIEF.md
# Per-Port Rollover Statistics Counter Bank

This block keeps a bank of event counters for every Ethernet port of a switch. Each port owns `NCNT` counters. Counters `0` to `NCNT-2` count single-cycle pulses from the MAC's event detectors. Counter `0` counts received frames whose length is valid. The last counter, index `NCNT-1`, counts frames dropped by filtering, and its pulses come from the queue manager. The counters never saturate: each one runs freely and wraps to zero.

Each wrap sets a sticky flag that names the port and counter that overflowed. Any flag that is not masked raises the host interrupt. Software can then add the lost range to its own long-term total.

The host reads a counter, a port's flag word or a port's mask word through a read port with one cycle of latency. It clears flags by writing ones to them. It sets the per-port interrupt mask with a write to the mask. A read returns the value the counter held before any increment that arrives in the same cycle.

Top module: `stat_bank`

## Requirements
- R1: After reset every counter, every wrap flag and every mask bit is 0, `irq` is 0 and `rd_valid` is 0.
- R2: A one-cycle pulse on `mac_evt[p*(NCNT-1)+c]`, with `c` from 0 to `NCNT-2`, adds exactly one to counter `c` of port `p`. Counter 0 counts received frames of valid length. No other counter changes.
- R3: The filtering counter, index `NCNT-1` of port `p`, adds one for each pulse on `qm_filt[p]`, and for no MAC event.
- R4: Pulses that arrive in the same cycle on different ports and counters are all counted in that cycle, with none lost.
- R5: A counter at its maximum value (all ones, `CW` bits) goes to 0 on its next event and does not saturate.
- R6: When counter `c` of port `p` wraps, bit `c` of port `p`'s flag word is set. The flag word reads at `rd_idx = NCNT`, zero-extended. The flag stays set until the host clears it.
- R7: `irq` is 1 exactly when some flag bit is set whose mask bit is 0.
- R8: A write with `wr_en=1` and `wr_mask=0` clears the flag bits of port `wr_port` where `wr_data` is 1. Bits where `wr_data` is 0 are left alone. A wrap in the same cycle keeps its flag set.
- R9: A read with `rd_en=1` gives `rd_valid=1` and `rd_data` in the next cycle. The value is the one held before any increment in the same cycle as the read. `rd_idx` selects counter `0..NCNT-1`, the flag word at `NCNT`, or the mask word at `NCNT+1`.
- R10: A write with `wr_en=1` and `wr_mask=1` loads `wr_data` into port `wr_port`'s mask word, readable at `rd_idx = NCNT+1`. Masking suppresses `irq` but leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_evt | input | NPORTS*(NCNT-1) | MAC event pulses, bit p*(NCNT-1)+c for counter c of port p |
| qm_filt | input | NPORTS | Queue-manager filtering pulses, one per port |
| rd_en | input | 1 | Host read strobe |
| rd_port | input | PW | Port to read |
| rd_idx | input | IW | Counter index, NCNT for flags, NCNT+1 for mask |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | CW | Read data |
| wr_en | input | 1 | Host write strobe |
| wr_mask | input | 1 | 0 clears flags (write-one-to-clear), 1 loads the mask |
| wr_port | input | PW | Port to write |
| wr_data | input | NCNT | Clear bits or mask value |
| irq | output | 1 | Interrupt: some flag set and not masked |

## Verification
The bench drives a counter to all ones and checks that the next pulse takes it to zero. A saturating design would stay at the maximum, and a design that loses the carry would set no flag. It sends pulses to every port and every counter in one cycle, so a design that arbitrates or shares an adder would count fewer. It reads a counter in the same cycle as an increment to it, which catches a read that returns the new value or a torn value. It also races a clear against a fresh wrap and applies a clear with only some bits set, so a design that lets clears win the race, or wipes the whole word, leaves a wrong flag word.

// File: rtl/stat_bank.sv
module stat_bank #(
  parameter int NPORTS = 4,
  parameter int NCNT   = 4,
  parameter int CW     = 32,
  localparam int NMAC  = NCNT - 1,
  localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int IW    = $clog2(NCNT + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORTS*NMAC-1:0] mac_evt,
  input  logic [NPORTS-1:0]      qm_filt,
  input  logic                   rd_en,
  input  logic [PW-1:0]          rd_port,
  input  logic [IW-1:0]          rd_idx,
  output logic                   rd_valid,
  output logic [CW-1:0]          rd_data,
  input  logic                   wr_en,
  input  logic                   wr_mask,
  input  logic [PW-1:0]          wr_port,
  input  logic [NCNT-1:0]        wr_data,
  output logic                   irq
);

  logic [CW-1:0]                  cnt_flat [NPORTS*NCNT];
  logic [NPORTS-1:0][NCNT-1:0]    wrap;
  logic [NPORTS-1:0][NCNT-1:0]    flag_q;
  logic [NPORTS-1:0][NCNT-1:0]    mask_q;
  logic [CW-1:0]                  rd_mux;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
      logic          inc;
      logic [CW-1:0] cnt_q;
      if (c == NCNT - 1) begin : g_filt
        assign inc = qm_filt[p];
      end else begin : g_mac
        assign inc = mac_evt[p*NMAC + c];
      end
      always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
      end
      assign wrap[p][c]           = inc & (&cnt_q);
      assign cnt_flat[p*NCNT + c] = cnt_q;
    end

    logic clr_hit, msk_hit;
    assign clr_hit = wr_en && !wr_mask && (wr_port == PW'(p));
    assign msk_hit = wr_en &&  wr_mask && (wr_port == PW'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[p] <= '0;
        mask_q[p] <= '0;
      end else begin
        flag_q[p] <= (flag_q[p] & ~(clr_hit ? wr_data : '0)) | wrap[p];
        if (msk_hit) mask_q[p] <= wr_data;
      end
    end
  end

  assign irq = |(flag_q & ~mask_q);

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (rd_port == PW'(p)) begin
        for (int c = 0; c < NCNT; c++)
          if (rd_idx == IW'(c)) rd_mux = cnt_flat[p*NCNT + c];
        if (rd_idx == IW'(NCNT))     rd_mux = CW'(flag_q[p]);
        if (rd_idx == IW'(NCNT + 1)) rd_mux = CW'(mask_q[p]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

endmodule

module stat_bank_chk #(
  parameter int NPORTS = 4,
  parameter int NCNT   = 4,
  localparam int NB    = NPORTS * NCNT
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          wr_en,
  input logic          wr_mask,
  input logic          irq,
  input logic [NB-1:0] flag_q,
  input logic [NB-1:0] mask_q
);

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid); // R9
  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid); // R9
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (flag_q != '0)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && !wr_mask) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R8
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && wr_mask) |=> $stable(mask_q)); // R10

endmodule

bind stat_bank stat_bank_chk #(.NPORTS(NPORTS), .NCNT(NCNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .wr_en(wr_en), .wr_mask(wr_mask), .irq(irq),
  .flag_q(flag_q), .mask_q(mask_q)
);

// File: tb/stat_bank_tb.sv
module stat_bank_tb_top;
  localparam int NP = 4, NC = 4, CW = 8, NM = NC - 1;
  localparam int PW = 2, IW = 3;

  logic clk = 0, rst_n = 0;
  logic [NP*NM-1:0] mac_evt = '0;
  logic [NP-1:0]    qm_filt = '0;
  logic rd_en = 0, wr_en = 0, wr_mask = 0;
  logic [PW-1:0] rd_port = '0, wr_port = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [NC-1:0] wr_data = '0;
  logic rd_valid, irq;
  logic [CW-1:0] rd_data;

  int checks = 0, errors = 0;
  int exp_cnt [NP][NC];

  stat_bank #(.NPORTS(NP), .NCNT(NC), .CW(CW)) dut_i (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(logic [NP*NM-1:0] m, logic [NP-1:0] q);
    @(negedge clk); mac_evt = m; qm_filt = q;
    @(negedge clk); mac_evt = '0; qm_filt = '0;
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < NM; c++) if (m[p*NM+c]) exp_cnt[p][c] = (exp_cnt[p][c] + 1) % 256;
      if (q[p]) exp_cnt[p][NC-1] = (exp_cnt[p][NC-1] + 1) % 256;
    end
  endtask

  task automatic rd(int p, int i, output int v);
    @(negedge clk); rd_en = 1; rd_port = PW'(p); rd_idx = IW'(i);
    @(negedge clk); rd_en = 0;
    chk("R9 valid", int'(rd_valid), 1);
    v = int'(rd_data);
  endtask

  task automatic wr(bit m, int p, int d);
    @(negedge clk); wr_en = 1; wr_mask = m; wr_port = PW'(p); wr_data = NC'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic check_all(string req);
    int v;
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < NC; c++) begin
        rd(p, c, v); chk(req, v, exp_cnt[p][c]);
      end
  endtask

  task automatic t_reset;
    int v;
    chk("R1 irq", int'(irq), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    check_all("R1 counter");
    for (int p = 0; p < NP; p++) begin
      rd(p, NC, v);   chk("R1 flags", v, 0);
      rd(p, NC+1, v); chk("R1 mask", v, 0);
    end
  endtask

  task automatic t_single;
    pulse(1 << 0, '0);
    pulse(1 << (2*NM + 1), '0);
    pulse(1 << (2*NM + 1), '0);
    check_all("R2 single events");
  endtask

  task automatic t_filter;
    pulse('0, 4'b0010);
    pulse('0, 4'b1010);
    check_all("R3 filter counter");
  endtask

  task automatic t_simul;
    pulse('1, '1);
    pulse({NP*NM{1'b1}} ^ 12'h5A5, 4'b0110);
    check_all("R4 simultaneous");
  endtask

  task automatic t_wrap;
    int v;
    int n = 255 - exp_cnt[2][1];
    for (int k = 0; k < n; k++) pulse(1 << (2*NM + 1), '0);
    rd(2, 1, v); chk("R5 at max", v, 255);
    chk("R6 no flag before wrap", int'(irq), 0);
    pulse(1 << (2*NM + 1), '0);
    rd(2, 1, v); chk("R5 wraps to zero", v, 0);
    rd(2, NC, v); chk("R6 flag bit", v, 2);
    rd(1, NC, v); chk("R6 other port flag", v, 0);
    chk("R7 irq on flag", int'(irq), 1);
  endtask

  task automatic t_mask;
    int v;
    wr(1, 2, 4'b0010);
    rd(2, NC+1, v); chk("R10 mask read", v, 2);
    chk("R7 irq masked", int'(irq), 0);
    rd(2, NC, v); chk("R10 flag kept under mask", v, 2);
    wr(1, 0, 4'b0010);
    chk("R7 other port mask no effect", int'(irq), 0);
    wr(1, 2, 0);
    chk("R7 irq unmasked", int'(irq), 1);
    wr(1, 0, 0);
  endtask

  task automatic t_clear;
    int v;
    wr(0, 2, 4'b0001);
    rd(2, NC, v); chk("R8 partial clear keeps bit", v, 2);
    wr(0, 2, 4'b0010);
    rd(2, NC, v); chk("R8 clear", v, 0);
    chk("R7 irq after clear", int'(irq), 0);
    for (int k = exp_cnt[0][0]; k < 255; k++) pulse(1, '0);
    @(negedge clk); mac_evt = 1; wr_en = 1; wr_mask = 0; wr_port = 0; wr_data = 4'b0001;
    @(negedge clk); mac_evt = 0; wr_en = 0; exp_cnt[0][0] = 0;
    rd(0, NC, v); chk("R8 wrap beats clear", v, 1);
    wr(0, 0, 4'b1111);
    chk("R8 irq cleared", int'(irq), 0);
  endtask

  task automatic t_coherent;
    int v;
    @(negedge clk); rd_en = 1; rd_port = 3; rd_idx = NC - 1; qm_filt = 4'b1000;
    @(negedge clk); rd_en = 0; qm_filt = 0;
    chk("R9 pre-increment value", int'(rd_data), exp_cnt[3][NC-1]);
    exp_cnt[3][NC-1]++;
    rd(3, NC-1, v); chk("R9 increment applied", v, exp_cnt[3][NC-1]);
    @(negedge clk);
    chk("R9 valid drops", int'(rd_valid), 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) for (int c = 0; c < NC; c++) exp_cnt[p][c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_filter();
    t_simul();
    t_wrap();
    t_mask();
    t_clear();
    t_coherent();
    check_all("R4 final totals");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule